// File: doc/BRIEF.md
# Dependency-Driven Task Dispatcher

This block runs a task graph on a pool of identical cores. Software first loads one descriptor per task into an internal table. A descriptor holds whether the task runs once or is replicated, how many predecessors it waits for, two successor masks, a conditional flag, the data address of its replication count and its code entry point. A pulse on `start` arms every task's pending counter from the table. Tasks whose counter is already zero are marked ready.

A single picker takes the lowest-numbered ready task. For a replicated task it first fetches the instance count from shared memory. It then hands out one instance per cycle to an idle core, which it finds by a rotating search. Every dispatch carries the task number, the entry point and the instance number. Cores report completion by naming themselves and returning one result bit. When the last instance of a task finishes, the result bit decides which successor mask is released, and each released task's pending counter drops by one. Replication counts of zero complete at once. The run ends when a chosen final task completes.

Top module: `task_sched`

## Requirements
- R1: After reset, `busy`, `done`, `disp_valid` and `mem_rd` are all low.
- R2: On `start`, every task whose predecessor count is 0 becomes ready. Any other task becomes ready only when that many predecessor completions have released it, so a join node waits for all of its inputs.
- R3: A task with `cfg_dup`=0 is dispatched exactly once, with instance number 0.
- R4: A task with `cfg_dup`=1 causes one `mem_rd` at its `cfg_qaddr`. The value returned on `mem_rdata` in the following cycle is its instance count q. The task is then dispatched q times, with instance numbers 0 through q-1 in increasing order, each once, all carrying the task's `cfg_entry`.
- R5: A replicated task releases its successors only after completions for all q of its instances have arrived.
- R6: A replicated task whose count reads as 0 is never dispatched, and its `cfg_succ` successors are released immediately.
- R7: For a task with `cfg_cond`=1, the `cmp_flag` of its final completion selects the mask to release: 1 releases `cfg_succ` and 0 releases `cfg_alt`. A task with `cfg_cond`=0 always releases `cfg_succ`, whatever the flag.
- R8: At most one dispatch happens per cycle, and only to a core that is idle. The core is the first idle one found by searching upward, with wrap-around, from the core after the most recently granted one. After reset the search starts at core 0.
- R9: `done` rises and `busy` falls in the cycle after the final task (`fin_task`) completes. `done` stays high until the next accepted `start`, which raises `busy` and clears `done` one cycle later.
- R10: While `busy` is high, table writes and `start` pulses have no effect.
- R11: `mem_rd` is asserted only while `busy` is high, and only once for each replicated task that is launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | TW | Task slot being written |
| cfg_dup | input | 1 | 1: replicated task, 0: single run |
| cfg_npred | input | CW | Number of predecessor releases to wait for |
| cfg_succ | input | NT | Successor mask released normally |
| cfg_alt | input | NT | Successor mask released on flag 0 for conditional tasks |
| cfg_cond | input | 1 | Task has a conditional exit |
| cfg_qaddr | input | AW | Memory address of the instance count |
| cfg_entry | input | EW | Code entry point |
| fin_task | input | TW | Task whose completion ends the run |
| start | input | 1 | Begin a run |
| mem_rd | output | 1 | Instance-count read request |
| mem_addr | output | AW | Read address |
| mem_rdata | input | QW | Count, valid the cycle after `mem_rd` |
| disp_valid | output | 1 | Dispatch this cycle |
| disp_core | output | KW | Target core |
| disp_task | output | TW | Task number |
| disp_entry | output | EW | Entry point |
| disp_inst | output | QW | Instance number |
| cmp_valid | input | 1 | Completion message |
| cmp_core | input | KW | Core reporting completion |
| cmp_flag | input | 1 | Result bit used by conditional tasks |
| busy | output | 1 | Graph running |
| done | output | 1 | Final task finished |

## Verification
Four graphs are run. The first is a fork and join with a replicated middle task. The second is the same graph with a count of zero, which separates early release from a missed release. The third is a single replicated task swept over counts from 1 to 12, which exposes off-by-one errors in instance numbering and termination. The fourth is a conditional branch run with both flag values and a non-conditional fork run with flag 0, which show whether the selected mask follows the flag. A disturbed run tries a table write and a second `start` in the middle of a graph; a later rerun shows whether either one reached the table or the counters. The bench core model finishes instances with latencies that depend on core and instance. This mixes the order of completions, so the rotating core search is checked against many different idle patterns.

// File: rtl/task_sched.sv
module task_sched #(
  parameter int NT = 8,
  parameter int NC = 4,
  parameter int QW = 6,
  parameter int AW = 8,
  parameter int EW = 16,
  localparam int TW = $clog2(NT),
  localparam int CW = $clog2(NT + 1),
  localparam int KW = $clog2(NC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [TW-1:0] cfg_idx,
  input  logic          cfg_dup,
  input  logic [CW-1:0] cfg_npred,
  input  logic [NT-1:0] cfg_succ,
  input  logic [NT-1:0] cfg_alt,
  input  logic          cfg_cond,
  input  logic [AW-1:0] cfg_qaddr,
  input  logic [EW-1:0] cfg_entry,
  input  logic [TW-1:0] fin_task,
  input  logic          start,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [QW-1:0] mem_rdata,
  output logic          disp_valid,
  output logic [KW-1:0] disp_core,
  output logic [TW-1:0] disp_task,
  output logic [EW-1:0] disp_entry,
  output logic [QW-1:0] disp_inst,
  input  logic          cmp_valid,
  input  logic [KW-1:0] cmp_core,
  input  logic          cmp_flag,
  output logic          busy,
  output logic          done
);
  typedef enum logic [1:0] {S_PICK, S_QRD, S_ISSUE} st_t;

  logic [NT-1:0] t_dup, t_cond;
  logic [CW-1:0] t_np  [NT];
  logic [NT-1:0] t_succ[NT];
  logic [NT-1:0] t_alt [NT];
  logic [AW-1:0] t_qa  [NT];
  logic [EW-1:0] t_ep  [NT];

  logic [CW-1:0] pend [NT];
  logic [CW-1:0] dec  [NT];
  logic [QW-1:0] left [NT];
  logic [NT-1:0] rdy;
  logic [NC-1:0] cbusy;
  logic [TW-1:0] ctask [NC];
  logic [KW-1:0] rr, gi;
  logic [TW-1:0] cur, pk, ct;
  logic [QW-1:0] inst, quota;
  logic          running, done_q, have_rdy, have_idle;
  logic          start_ok, take, cmp_last, zq, fin_hit;
  logic [NT-1:0] rel_a, rel_b;
  st_t           st;

  assign start_ok = start && !running;
  assign have_rdy = |rdy;
  assign take     = running && st == S_PICK && have_rdy;
  assign ct       = ctask[cmp_core];
  assign cmp_last = cmp_valid && left[ct] == QW'(1);
  assign zq       = st == S_QRD && mem_rdata == '0;
  assign rel_a    = !cmp_last ? '0 : (t_cond[ct] && !cmp_flag) ? t_alt[ct] : t_succ[ct];
  assign rel_b    = zq ? t_succ[cur] : '0;
  assign fin_hit  = (cmp_last && ct == fin_task) || (zq && cur == fin_task);

  assign mem_rd     = take && t_dup[pk];
  assign mem_addr   = t_qa[pk];
  assign disp_valid = st == S_ISSUE && have_idle;
  assign disp_core  = gi;
  assign disp_task  = cur;
  assign disp_entry = t_ep[cur];
  assign disp_inst  = inst;
  assign busy       = running;
  assign done       = done_q;

  always_comb begin
    pk = '0;
    for (int j = NT - 1; j >= 0; j--)
      if (rdy[j]) pk = TW'(j);
  end

  always_comb begin
    gi = '0;
    have_idle = 1'b0;
    for (int k = 0; k < NC; k++) begin
      int s;
      s = int'(rr) + k;
      if (s >= NC) s = s - NC;
      if (!have_idle && !cbusy[KW'(s)]) begin
        have_idle = 1'b1;
        gi = KW'(s);
      end
    end
  end

  always_comb
    for (int j = 0; j < NT; j++)
      dec[j] = CW'(rel_a[j]) + CW'(rel_b[j]);

  always_ff @(posedge clk)
    if (cfg_we && !running) begin
      t_dup[cfg_idx]  <= cfg_dup;
      t_cond[cfg_idx] <= cfg_cond;
      t_np[cfg_idx]   <= cfg_npred;
      t_succ[cfg_idx] <= cfg_succ;
      t_alt[cfg_idx]  <= cfg_alt;
      t_qa[cfg_idx]   <= cfg_qaddr;
      t_ep[cfg_idx]   <= cfg_entry;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdy <= '0;
      for (int j = 0; j < NT; j++) pend[j] <= '0;
    end else if (start_ok) begin
      for (int j = 0; j < NT; j++) begin
        pend[j] <= t_np[j];
        rdy[j]  <= t_np[j] == '0;
      end
    end else begin
      for (int j = 0; j < NT; j++)
        if (dec[j] != '0) begin
          pend[j] <= pend[j] - dec[j];
          if (pend[j] == dec[j]) rdy[j] <= 1'b1;
        end
      if (take) rdy[pk] <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_PICK;
      cur     <= '0;
      inst    <= '0;
      quota   <= '0;
      cbusy   <= '0;
      rr      <= '0;
      running <= 1'b0;
      done_q  <= 1'b0;
      for (int j = 0; j < NT; j++) left[j] <= '0;
      for (int c = 0; c < NC; c++) ctask[c] <= '0;
    end else begin
      if (start_ok) begin
        running <= 1'b1;
        done_q  <= 1'b0;
      end else if (fin_hit && running) begin
        running <= 1'b0;
        done_q  <= 1'b1;
      end
      if (cmp_valid) begin
        cbusy[cmp_core] <= 1'b0;
        left[ct]        <= left[ct] - QW'(1);
      end
      case (st)
        S_PICK:
          if (take) begin
            cur  <= pk;
            inst <= '0;
            if (t_dup[pk]) st <= S_QRD;
            else begin
              quota    <= QW'(1);
              left[pk] <= QW'(1);
              st       <= S_ISSUE;
            end
          end
        S_QRD: begin
          quota <= mem_rdata;
          if (mem_rdata == '0) st <= S_PICK;
          else begin
            left[cur] <= mem_rdata;
            st        <= S_ISSUE;
          end
        end
        default:
          if (have_idle) begin
            cbusy[gi] <= 1'b1;
            ctask[gi] <= cur;
            rr        <= (gi == KW'(NC - 1)) ? '0 : gi + KW'(1);
            inst      <= inst + QW'(1);
            if (inst == quota - QW'(1)) st <= S_PICK;
          end
      endcase
    end
endmodule

module task_sched_chk #(
  parameter int NC = 4,
  parameter int NT = 8,
  parameter int QW = 6,
  localparam int TW = $clog2(NT),
  localparam int KW = $clog2(NC)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          disp_valid,
  input logic [KW-1:0] disp_core,
  input logic [TW-1:0] disp_task,
  input logic [QW-1:0] disp_inst,
  input logic [NC-1:0] cbusy,
  input logic          mem_rd,
  input logic          busy,
  input logic          done
);
  assert_idle_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !cbusy[disp_core]);
  assert_core_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> cbusy[$past(disp_core)]);
  assert_read_in_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  assert_inst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && $past(disp_valid) && disp_task == $past(disp_task))
      |-> disp_inst == QW'($past(disp_inst) + 1'b1));
endmodule

bind task_sched task_sched_chk #(.NC(NC), .NT(NT), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .disp_valid(disp_valid),
  .disp_core(disp_core), .disp_task(disp_task), .disp_inst(disp_inst),
  .cbusy(cbusy), .mem_rd(mem_rd), .busy(busy), .done(done)
);

// File: tb/task_sched_bench.sv
`timescale 1ns/1ps
module task_sched_bench;
  localparam int NT = 8, NC = 4, QW = 6, AW = 8, EW = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_dup = 0, cfg_cond = 0, start = 0;
  logic [2:0] cfg_idx = 0, fin_task = 0;
  logic [3:0] cfg_npred = 0;
  logic [7:0] cfg_succ = 0, cfg_alt = 0, cfg_qaddr = 0;
  logic [15:0] cfg_entry = 0;
  logic mem_rd;
  logic [7:0] mem_addr;
  logic [5:0] mem_rdata = 0;
  logic disp_valid;
  logic [1:0] disp_core;
  logic [2:0] disp_task;
  logic [15:0] disp_entry;
  logic [5:0] disp_inst;
  logic cmp_valid = 0, cmp_flag = 0;
  logic [1:0] cmp_core = 0;
  logic busy, done;

  task_sched u_task_sched (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [5:0] mem [256];
  int exp_q [NT];
  logic [7:0] predm [NT];
  logic [15:0] ep [NT];
  int dcnt [NT], ccnt [NT];
  logic [63:0] imask [NT];
  logic [3:0] cb = 0;
  int ctr [NC], ctk [NC];
  int lastg = NC - 1, mrd = 0;
  bit flagv = 0;

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // core model: sample dispatch, serve memory, emit completions
  always @(negedge clk) if (rst_n) begin
    if (disp_valid) begin
      int t, c, ec;
      bit f;
      t = disp_task; c = disp_core; ec = 0; f = 0;
      for (int k = 0; k < NC; k++) begin
        int s;
        s = (lastg + 1 + k) % NC;
        if (!f && !cb[s]) begin f = 1; ec = s; end
      end
      chk(c == ec, "R8 round-robin core", c, ec);
      chk(!cb[c], "R8 target idle", cb[c], 0);
      chk(disp_entry == ep[t], "R4 entry point", disp_entry, ep[t]);
      chk(int'(disp_inst) < exp_q[t] && !imask[t][disp_inst], "R3/R4 instance", disp_inst, exp_q[t]);
      if (dcnt[t] == 0)
        for (int i = 0; i < NT; i++)
          if (predm[t][i] && exp_q[i] > 0)
            chk(ccnt[i] == exp_q[i], "R5/R2 predecessor finished", ccnt[i], exp_q[i]);
      dcnt[t]++;
      imask[t][disp_inst] = 1'b1;
      cb[c] = 1'b1;
      ctr[c] = 2 + (c + int'(disp_inst)) % 3;
      ctk[c] = t;
      lastg = c;
    end
    if (mem_rd) begin
      mrd++;
      mem_rdata <= mem[mem_addr];
    end
    cmp_valid <= 1'b0;
    for (int c = 0; c < NC; c++) if (cb[c] && ctr[c] > 0) ctr[c]--;
    begin
      bit f;
      f = 0;
      for (int c = 0; c < NC; c++)
        if (!f && cb[c] && ctr[c] == 0) begin
          f = 1;
          cb[c] = 1'b0;
          ccnt[ctk[c]]++;
          cmp_valid <= 1'b1;
          cmp_core <= 2'(c);
          cmp_flag <= flagv;
        end
    end
  end

  task automatic wr(input int i, input bit dup, input int np, input logic [7:0] s, input logic [7:0] a,
                    input bit cnd, input int qa, input int e, input bit acc);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(i); cfg_dup = dup; cfg_npred = 4'(np);
    cfg_succ = s; cfg_alt = a; cfg_cond = cnd; cfg_qaddr = 8'(qa); cfg_entry = 16'(e);
    @(negedge clk);
    cfg_we = 0;
    if (acc) ep[i] = 16'(e);
  endtask

  task automatic clear_all();
    for (int i = 0; i < NT; i++) begin
      wr(i, 0, 1, 0, 0, 0, 0, 16'h100 + i, 1);
      exp_q[i] = 0; predm[i] = 0;
    end
  endtask

  task automatic graph_a(input int q);
    clear_all();
    wr(0, 0, 0, 8'b0110, 0, 0, 0, 16'hA000, 1);
    wr(1, 1, 1, 8'b1000, 0, 0, 3, 16'hA100, 1);
    wr(2, 0, 1, 8'b1000, 0, 0, 0, 16'hA200, 1);
    wr(3, 0, 2, 0, 0, 0, 0, 16'hA300, 1);
    mem[3] = 6'(q);
    exp_q[0] = 1; exp_q[1] = q; exp_q[2] = 1; exp_q[3] = 1;
    predm[1] = 8'b0001; predm[2] = 8'b0001; predm[3] = 8'b0110;
  endtask

  task automatic run_graph(input int fin, input bit disturb, input int exp_mrd, input string tag);
    int n;
    for (int t = 0; t < NT; t++) begin dcnt[t] = 0; ccnt[t] = 0; imask[t] = 0; end
    mrd = 0;
    fin_task = 3'(fin);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy && !done, {"R9 start raises busy ", tag}, busy, 1);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk); n++;
      if (disturb && n == 3) begin
        wr(3, 0, 0, 0, 0, 0, 0, 16'hBEEF, 0);
        start = 1;
        @(negedge clk); start = 0;
      end
    end
    chk(done && !busy, {"R9 done after final ", tag}, done, 1);
    n = 0;
    while (cb != 0 && n < 100) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(done, {"R9 done held ", tag}, done, 1);
    for (int t = 0; t < NT; t++) begin
      chk(dcnt[t] == exp_q[t], {"R3/R4/R6/R7 dispatch count ", tag}, dcnt[t], exp_q[t]);
      chk(imask[t] == (64'd1 << exp_q[t]) - 64'd1, {"R4 instance set ", tag}, 0, 0);
    end
    chk(mrd == exp_mrd, {"R11 memory reads ", tag}, mrd, exp_mrd);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    for (int c = 0; c < NC; c++) begin ctr[c] = 0; ctk[c] = 0; end
    for (int t = 0; t < NT; t++) begin exp_q[t] = 0; predm[t] = 0; ep[t] = 0; dcnt[t] = 0; ccnt[t] = 0; imask[t] = 0; end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !disp_valid && !mem_rd, "R1 reset outputs", {busy, done, disp_valid, mem_rd}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", busy, 0);

    // fork/join with replicated middle task; flag 0 on non-conditional tasks (R2 R5 R7)
    flagv = 0;
    graph_a(5);
    run_graph(3, 0, 1, "forkjoin");

    // zero count (R6)
    graph_a(0);
    run_graph(3, 0, 1, "zero");

    // count sweep on a single replicated task (R4)
    for (int q = 1; q <= 12; q++) begin
      clear_all();
      wr(0, 1, 0, 0, 0, 0, 9, 16'hC000 + q, 1);
      mem[9] = 6'(q);
      exp_q[0] = q;
      run_graph(0, 0, 1, "sweep");
    end

    // conditional branch (R7)
    for (int f = 0; f < 2; f++) begin
      clear_all();
      wr(0, 0, 0, 8'b0010, 8'b0100, 1, 0, 16'hD000, 1);
      wr(1, 0, 1, 8'b1000, 0, 0, 0, 16'hD100, 1);
      wr(2, 0, 1, 8'b1000, 0, 0, 0, 16'hD200, 1);
      wr(3, 0, 1, 0, 0, 0, 0, 16'hD300, 1);
      flagv = f[0];
      exp_q[0] = 1; exp_q[1] = f; exp_q[2] = 1 - f; exp_q[3] = 1;
      predm[1] = 8'b0001; predm[2] = 8'b0001; predm[3] = f ? 8'b0010 : 8'b0100;
      run_graph(3, 0, 0, f ? "cond1" : "cond0");
    end

    // writes and start while busy are ignored (R10)
    flagv = 1;
    graph_a(4);
    run_graph(3, 1, 1, "R10 disturbed");
    run_graph(3, 0, 1, "R10 rerun");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule